// File: doc/BRIEF.md
# Serial Code-Memory Programming Controller

This block sits on the target side of a serial programming link. While the device's programming-mode input is held high, an external host clocks 32-bit command frames in on `mosi_i` with `sck_i`. The block decodes each frame and acts on a code memory held inside it. The supported commands are session enable, chip erase, byte write, byte read and signature read. Read results, the session acknowledge and signature bytes come back on `miso_o` during the last byte of the same frame.

Erase and write are self-timed by a counter on the system clock. `ready_o` stays low for the whole of each operation. A location that has been programmed can only lose set bits until the next erase, so reprogramming means erasing the whole array first. `sck_i` is sampled by the system clock and must run slower than one sixteenth of it. The erase time parameter must be at least the array depth, because the erase clears one location per cycle.

Top module: `isp_flash_ctrl`

## Requirements
- R1: After `rst_ni` is released, `ready_o` is high and `miso_o` is low.
- R2: A session starts with programming disabled. Until an enable frame has been accepted in the current session, read and signature frames return 00H and write and erase frames start nothing, so `ready_o` stays high.
- R3: An enable frame (bytes AC 53 xx xx) returns 69H in its fourth byte and enables the session.
- R4: An erase frame (bytes AC 80 xx xx) drives `ready_o` low for exactly ERASE_CYC system cycles. Afterwards every location reads FFH.
- R5: A read frame issued while an erase runs returns 00H.
- R6: A write frame (bytes 40 AH AL DD) drives `ready_o` low for exactly WRITE_CYC cycles. Afterwards an erased location holds DD.
- R7: A write to a location that is already programmed can only clear bits: the new value is the old value AND DD.
- R8: A signature frame (bytes 28 xx II xx) returns, in its fourth byte, 1EH for II=00H, 51H for II=01H and 06H for II=02H.
- R9: While `read_lock_i` is high, a read frame returns 00H. Signature frames are not affected by the lock.
- R10: A write or erase frame that arrives while an operation is running is discarded. The running operation is neither restarted nor extended.
- R11: The memory address is the low ADDR_W bits of the 16-bit address field (AH:AL). Higher bits are ignored.
- R12: Taking `prog_mode_i` low ends the session. It clears the enable and discards any partly received frame.
- R13: The link protocol is as follows. A frame is 32 bits sent MSB first. `mosi_i` is sampled on rising `sck_i`. `miso_o` changes on falling `sck_i`. A read frame (bytes 20 AH AL xx) returns the addressed byte in its fourth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_mode_i | input | 1 | High holds the device in serial programming mode |
| read_lock_i | input | 1 | Read protection; blocks read-back of code bytes |
| sck_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| ready_o | output | 1 | High when no erase or write is running |

## Verification
The bench writes a byte twice without an erase in between. A design that overwrites instead of ANDing would return the second value. It reads during an erase, where a design that forwards array data would return a stale nonzero byte. It also sends a write in the middle of an erase, which a design without busy gating would let restart the timer or corrupt the freshly erased array. The bench counts the exact number of low cycles on `ready_o`, which catches off-by-one timers. It sends a write with the high address bits set, to catch address aliasing faults. It drops programming mode in the middle of a frame, so that a design keeping a stale bit count or enable flag would misframe the next frame or accept an unenabled write.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_PREFIX  = 8'hAC;
  localparam logic [7:0] SUB_ENABLE = 8'h53;
  localparam logic [7:0] SUB_ERASE  = 8'h80;
  localparam logic [7:0] OP_WRITE   = 8'h40;
  localparam logic [7:0] OP_READ    = 8'h20;
  localparam logic [7:0] OP_SIG     = 8'h28;
  localparam logic [7:0] ACK_BYTE   = 8'h69;

  typedef enum logic [1:0] {OP_IDLE, OP_ERASING, OP_WRITING} op_e;

  function automatic logic [7:0] sig_byte(input logic [7:0] idx);
    case (idx)
      8'h00:   return 8'h1E;
      8'h01:   return 8'h51;
      8'h02:   return 8'h06;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], sck_i};
  end

  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

  // R13: a synchronized edge lasts one system cycle
  assert_rise_single_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/isp_frame_shift.sv
module isp_frame_shift #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  mosi_i,
  input  logic [7:0]            resp_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  done_o,
  output logic                  miso_o
);
  localparam int CNT_W   = $clog2(FRAME_BITS);
  localparam int RESP_AT = FRAME_BITS - 8;

  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] rx_q;
  logic [7:0]            tx_q;
  logic                  done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rise_i) begin
        rx_q <= {rx_q[FRAME_BITS-2:0], mosi_i};
        if (cnt_q == CNT_W'(FRAME_BITS-1)) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      // response byte is loaded on the fall that opens the last byte
      if (fall_i) begin
        if (cnt_q == CNT_W'(RESP_AT)) tx_q <= resp_i;
        else                          tx_q <= {tx_q[6:0], 1'b0};
      end
    end
  end

  assign frame_o = rx_q;
  assign done_o  = done_q;
  assign miso_o  = tx_q[7];

  assert_done_after_last_bit_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(rise_i) && cnt_q == '0);
endmodule

// File: rtl/isp_code_array.sv
module isp_code_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              ers_en_i,
  input  logic [ADDR_W-1:0] ers_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (ers_en_i)     mem_q[ers_addr_i] <= 8'hFF;
    else if (wr_en_i) mem_q[wr_addr_i]  <= mem_q[wr_addr_i] & wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  assert_erase_fills_ones_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_en_i |=> mem_q[$past(ers_addr_i)] == 8'hFF);

  assert_program_clears_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !ers_en_i |=>
      (mem_q[$past(wr_addr_i)] | $past(mem_q[wr_addr_i])) == $past(mem_q[wr_addr_i]));
endmodule

// File: rtl/isp_flash_ctrl.sv
module isp_flash_ctrl
  import isp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ERASE_CYC = 4200,
  parameter int WRITE_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_mode_i,
  input  logic read_lock_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic ready_o
);
  localparam int FRAME_BITS = 32;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int MAX_CYC    = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int TMR_W      = $clog2(MAX_CYC + 1);

  logic                  rise, fall, done;
  logic [FRAME_BITS-1:0] frame;
  logic [7:0]            resp, rd_data;
  logic                  enabled_q;
  op_e                   op_q;
  logic [TMR_W-1:0]      tmr_q, tmr_last;
  logic [ADDR_W-1:0]     wr_addr_q;
  logic [7:0]            wr_data_q;
  logic                  wr_en, ers_en;

  isp_sck_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .sck_i, .rise_o(rise), .fall_o(fall)
  );

  isp_frame_shift #(.FRAME_BITS(FRAME_BITS)) i_shift (
    .clk_i, .rst_ni, .clr_i(!prog_mode_i), .rise_i(rise), .fall_i(fall),
    .mosi_i, .resp_i(resp), .frame_o(frame), .done_o(done), .miso_o
  );

  isp_code_array #(.ADDR_W(ADDR_W)) i_array (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr_q), .wr_data_i(wr_data_q),
    .ers_en_i(ers_en), .ers_addr_i(ADDR_W'(tmr_q)),
    .rd_addr_i(frame[ADDR_W-1:0]), .rd_data_o(rd_data)
  );

  generate
    if (ADDR_W < 16) begin : g_hi_addr
      logic unused_hi_addr;
      assign unused_hi_addr = ^frame[15:ADDR_W];
    end
  endgenerate

  // header view while the first three bytes sit in the low bits
  logic [7:0] hdr_op, hdr_sub;
  assign hdr_op  = frame[23:16];
  assign hdr_sub = frame[15:8];

  always_comb begin
    resp = 8'h00;
    if (hdr_op == OP_PREFIX && hdr_sub == SUB_ENABLE) begin
      resp = ACK_BYTE;
    end else if (enabled_q) begin
      if (hdr_op == OP_READ) begin
        if (op_q != OP_ERASING && !read_lock_i) resp = rd_data;
      end else if (hdr_op == OP_SIG) begin
        resp = sig_byte(frame[7:0]);
      end
    end
  end

  // full-frame view once all 32 bits are in
  logic [7:0] f_op, f_sub;
  logic       cmd_en, is_enable, start_erase, start_write;
  assign f_op        = frame[31:24];
  assign f_sub       = frame[23:16];
  assign cmd_en      = done && prog_mode_i;
  assign is_enable   = f_op == OP_PREFIX && f_sub == SUB_ENABLE;
  assign start_erase = cmd_en && enabled_q && op_q == OP_IDLE &&
                       f_op == OP_PREFIX && f_sub == SUB_ERASE;
  assign start_write = cmd_en && enabled_q && op_q == OP_IDLE && f_op == OP_WRITE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  enabled_q <= 1'b0;
    else if (!prog_mode_i)        enabled_q <= 1'b0;
    else if (cmd_en && is_enable) enabled_q <= 1'b1;
  end

  assign tmr_last = (op_q == OP_ERASING) ? TMR_W'(ERASE_CYC - 1) : TMR_W'(WRITE_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      tmr_q     <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (start_erase) begin
      op_q  <= OP_ERASING;
      tmr_q <= '0;
    end else if (start_write) begin
      op_q      <= OP_WRITING;
      tmr_q     <= '0;
      wr_addr_q <= frame[ADDR_W+7:8];
      wr_data_q <= frame[7:0];
    end else if (op_q != OP_IDLE) begin
      if (tmr_q == tmr_last) op_q <= OP_IDLE;
      tmr_q <= tmr_q + 1'b1;
    end
  end

  // erase sweeps one location per cycle; write commits on its last cycle
  assign ers_en  = op_q == OP_ERASING && int'(tmr_q) < DEPTH;
  assign wr_en   = op_q == OP_WRITING && tmr_q == tmr_last;
  assign ready_o = op_q == OP_IDLE;

  assert_locked_until_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_q && done && ready_o |=> ready_o);

  assert_busy_discards_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && done && tmr_q != tmr_last |=> !ready_o && tmr_q == $past(tmr_q) + 1'b1);

  assert_session_end_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_mode_i |=> !enabled_q);
endmodule

// File: tb/test_isp_flash_ctrl.sv
module test_isp_flash_ctrl;
  localparam int ADDR_W    = 12;
  localparam int ERASE_CYC = 4200;
  localparam int WRITE_CYC = 40;
  localparam int HALF      = 20;
  localparam int NVEC      = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog = 1'b0, lock = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, ready;
  int   nchk = 0, nerr = 0, low_cnt = 0;

  always #4 clk = ~clk;

  isp_flash_ctrl #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) i_isp_flash_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .prog_mode_i(prog), .read_lock_i(lock),
    .sck_i(sck), .mosi_i(mosi), .miso_o(miso), .ready_o(ready)
  );

  always @(negedge clk) if (!ready) low_cnt++;

  // {req, check, frame, expected fourth byte}
  localparam logic [44:0] VEC [NVEC] = '{
    {4'd3,  1'b1, 32'hAC53_0000, 8'h69},  // R3 enable ack
    {4'd4,  1'b0, 32'hAC80_0000, 8'h00},  // R4 erase
    {4'd4,  1'b1, 32'h2001_2300, 8'hFF},  // R4 erased
    {4'd4,  1'b1, 32'h200F_FF00, 8'hFF},  // R4 last location
    {4'd6,  1'b0, 32'h4001_23A5, 8'h00},  // R6 write
    {4'd13, 1'b1, 32'h2001_2300, 8'hA5},  // R13 read back
    {4'd7,  1'b0, 32'h4001_230F, 8'h00},  // R7 rewrite
    {4'd7,  1'b1, 32'h2001_2300, 8'h05},  // R7 AND result
    {4'd11, 1'b0, 32'h40F0_F53C, 8'h00},  // R11 high bits set
    {4'd11, 1'b1, 32'h2000_F500, 8'h3C},  // R11 alias
    {4'd8,  1'b1, 32'h2800_0000, 8'h1E},  // R8
    {4'd8,  1'b1, 32'h2800_0100, 8'h51},  // R8
    {4'd8,  1'b1, 32'h2800_0200, 8'h06}   // R8
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, input int nbits, output logic [7:0] rsp);
    rsp = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); mosi = w[31-i];
      repeat (HALF - 1) @(negedge clk);
      if (i >= 24) rsp = {rsp[6:0], miso};
      @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
  endtask

  task automatic wait_ready();
    repeat (8) @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic clr_low();
    @(posedge clk); low_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, ready, 1, "ready after reset");  // R1
    check(1, miso, 0, "miso after reset");    // R1

    prog = 1'b1;
    repeat (10) @(negedge clk);
    // R2: not yet enabled
    xfer(32'h2800_0100, 32, r); check(2, r, 8'h00, "sig before enable");
    clr_low();
    xfer(32'hAC80_0000, 32, r); wait_ready();
    check(2, low_cnt, 0, "erase before enable busy cycles");

    for (int v = 0; v < NVEC; v++) begin
      xfer(VEC[v][39:8], 32, r);
      if (VEC[v][40]) check(int'(VEC[v][44:41]), r, VEC[v][7:0], "vector response");
      wait_ready();
    end

    // R6: exact write time and result
    clr_low();
    xfer(32'h4002_005A, 32, r); wait_ready();
    check(6, low_cnt, WRITE_CYC, "write busy cycles");
    xfer(32'h2002_0000, 32, r); check(6, r, 8'h5A, "write read back");

    // R4 R5 R10: erase with a read and a write arriving mid-erase
    clr_low();
    xfer(32'hAC80_0000, 32, r);
    xfer(32'h2001_2300, 32, r); check(5, r, 8'h00, "read during erase");
    xfer(32'h4000_1000, 32, r);
    wait_ready();
    check(10, low_cnt, ERASE_CYC, "erase busy cycles with discarded write");
    xfer(32'h2000_1000, 32, r); check(10, r, 8'hFF, "discarded write left no trace");
    xfer(32'h2002_0000, 32, r); check(4, r, 8'hFF, "erase cleared written byte");

    // R9: read lock
    xfer(32'h4000_2077, 32, r); wait_ready();
    lock = 1'b1;
    xfer(32'h2000_2000, 32, r); check(9, r, 8'h00, "locked read");
    xfer(32'h2800_0100, 32, r); check(9, r, 8'h51, "signature under lock");
    lock = 1'b0;
    xfer(32'h2000_2000, 32, r); check(9, r, 8'h77, "unlocked read");

    // R12: leave mid-frame, re-enter without enable
    xfer(32'hAC53_0000, 16, r);
    prog = 1'b0;
    repeat (10) @(negedge clk);
    prog = 1'b1;
    repeat (10) @(negedge clk);
    clr_low();
    xfer(32'h4000_3011, 32, r); wait_ready();
    check(12, low_cnt, 0, "write after session end busy cycles");
    xfer(32'hAC53_0000, 32, r); check(12, r, 8'h69, "framing restarts after partial frame");
    xfer(32'h2000_3000, 32, r); check(12, r, 8'hFF, "write without enable ignored");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule